// File: doc/BRIEF.md
# Ticket Lock Arbiter Unit

This block is a single hardware lock shared by a fixed set of requesters. It grants mutual exclusion strictly in the order the requesters arrived. It keeps two counters: a ticket dispenser and a serving counter. When a requester arrives, the dispenser is read and incremented in the same step, and the value read is returned as that requester's ticket. This happens whether or not the lock is currently free. A requester owns the lock while the serving counter equals its ticket, and a release by the owner advances the serving counter by one.

Each requester has its own acquire and release handshake and its own grant line. Each also has a backoff hint, which is the distance between its ticket and the serving counter. Spin loops can use this hint to scale their polling interval. A global queue depth output reports how many tickets are outstanding. If several acquires arrive in the same cycle, a fixed-priority picker orders them, one per cycle, and each gets the next consecutive ticket.

Top module: `ticket_lock_unit`

## Requirements
- R1: After reset, both counters are zero. No requester holds a ticket, all grant, acknowledge and error outputs are low, and the queue depth is zero.
- R2: An acquire request sampled at a clock edge from a requester without a ticket, and selected by the picker, is handled as follows. In the next cycle it sees a one-cycle `acq_ack` bit, and `acq_ticket` carries the dispenser value read. The dispenser then increments by one. `acq_ticket` is zero in cycles with no acknowledge.
- R3: When several eligible acquire requests are sampled together, only the lowest-indexed one is served in that cycle. Requesters that keep their request up are served in later cycles, in index order, with consecutive tickets.
- R4: An acquire request from a requester that already holds a ticket has no effect. It produces no acknowledge, and both the queue depth and the dispenser are unchanged.
- R5: `granted[i]` is high exactly while requester i holds a ticket equal to the serving counter. At most one grant bit is high at any time.
- R6: A release pulse from the granted requester produces `rel_ack` for that requester in the next cycle. It also advances the serving counter by one and frees that requester's ticket.
- R7: A release pulse from a requester that is not granted is ignored. The serving counter does not move, no `rel_ack` is given, and `rel_err` pulses high for one cycle in the next cycle.
- R8: The lock passes between requesters in the order their tickets were issued. A grant bit only falls in the cycle its owner's `rel_ack` appears.
- R9: Both counters are TKT_W bits wide and wrap modulo 2^TKT_W. Ticket comparison and all differences are taken modulo 2^TKT_W.
- R10: `queue_depth` equals the dispenser minus the serving counter, modulo 2^TKT_W.
- R11: For a requester holding a ticket, its `backoff_hint` field (bits i*TKT_W upward) equals its ticket minus the serving counter, modulo 2^TKT_W. The field is zero for the owner and for requesters with no ticket.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acq_req | input | NUM_REQ | Per-requester acquire request, held until acknowledged |
| acq_ack | output | NUM_REQ | One-cycle acquire acknowledge, at most one bit set |
| acq_ticket | output | TKT_W | Ticket handed out with the acknowledge |
| rel_req | input | NUM_REQ | Per-requester release pulse |
| rel_ack | output | NUM_REQ | One-cycle acknowledge of an accepted release |
| rel_err | output | 1 | One-cycle flag for a release from a non-owner |
| granted | output | NUM_REQ | Per-requester lock ownership |
| queue_depth | output | TKT_W | Outstanding tickets, including the owner's |
| backoff_hint | output | NUM_REQ*TKT_W | Per-requester distance from ticket to serving counter |

## Verification
The assertions assume three things about the inputs. Release is a single-cycle pulse per release attempt. The number of tickets outstanding never exceeds 2^TKT_W - 1, because each requester holds at most one ticket and NUM_REQ stays below 2^TKT_W. Grant uniqueness and the one-step changes in queue depth depend on these assumptions. The stimulus keeps within them in two ways: it drives releases only as one-cycle pulses, and it uses four requesters with 3-bit counters. The random phase mixes legal and illegal releases and random acquire patterns, so the counters wrap many times.

// File: rtl/tlk_pkg.sv
package tlk_pkg;

    // Occupancy of one requester's ticket slot
    typedef enum logic {
        SLOT_FREE = 1'b0,
        SLOT_HELD = 1'b1
    } slot_state_e;

    // Classification of a release pulse from one requester
    typedef struct packed {
        logic good;
        logic bad;
    } rel_outcome_t;

    function automatic rel_outcome_t classify_release(input logic pulse, input logic owns);
        rel_outcome_t o;
        o.good = pulse & owns;
        o.bad  = pulse & ~owns;
        return o;
    endfunction

endpackage

// File: rtl/tlk_arbiter.sv
module tlk_arbiter #(
    parameter int NUM_REQ = 4
) (
    input  logic [NUM_REQ-1:0] req,
    output logic [NUM_REQ-1:0] gnt,
    output logic               any
);
    logic [NUM_REQ-1:0] lower_busy;

    assign lower_busy[0] = 1'b0;
    for (genvar i = 1; i < NUM_REQ; i++) begin : g_chain
        assign lower_busy[i] = lower_busy[i-1] | req[i-1];
    end

    assign gnt = req & ~lower_busy;
    assign any = |req;
endmodule

// File: rtl/tlk_counters.sv
module tlk_counters #(
    parameter int TKT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bump_next,
    input  logic             bump_serve,
    output logic [TKT_W-1:0] next_q,
    output logic [TKT_W-1:0] serve_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            next_q  <= '0;
            serve_q <= '0;
        end else begin
            if (bump_next)  next_q  <= next_q + 1'b1;
            if (bump_serve) serve_q <= serve_q + 1'b1;
        end
    end
endmodule

// File: rtl/tlk_slot.sv
module tlk_slot
    import tlk_pkg::*;
#(
    parameter int TKT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [TKT_W-1:0] load_tkt,
    input  logic             clear,
    input  logic [TKT_W-1:0] serve,
    output logic             held,
    output logic             own,
    output logic [TKT_W-1:0] hint
);
    slot_state_e      state_q;
    logic [TKT_W-1:0] tkt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SLOT_FREE;
            tkt_q   <= '0;
        end else if (load) begin
            state_q <= SLOT_HELD;
            tkt_q   <= load_tkt;
        end else if (clear) begin
            state_q <= SLOT_FREE;
        end
    end

    assign held = (state_q == SLOT_HELD);
    assign own  = held && (tkt_q == serve);
    assign hint = held ? (tkt_q - serve) : '0;
endmodule

// File: rtl/ticket_lock_unit.sv
module ticket_lock_unit
    import tlk_pkg::*;
#(
    parameter int NUM_REQ = 4,
    parameter int TKT_W   = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_REQ-1:0]       acq_req,
    output logic [NUM_REQ-1:0]       acq_ack,
    output logic [TKT_W-1:0]         acq_ticket,
    input  logic [NUM_REQ-1:0]       rel_req,
    output logic [NUM_REQ-1:0]       rel_ack,
    output logic                     rel_err,
    output logic [NUM_REQ-1:0]       granted,
    output logic [TKT_W-1:0]         queue_depth,
    output logic [NUM_REQ*TKT_W-1:0] backoff_hint
);
    localparam int HINT_W = NUM_REQ * TKT_W;

    logic [NUM_REQ-1:0] held_vec;
    logic [NUM_REQ-1:0] own_vec;
    logic [NUM_REQ-1:0] eligible;
    logic [NUM_REQ-1:0] win;
    logic               win_any;
    logic [NUM_REQ-1:0] rel_good;
    logic [NUM_REQ-1:0] rel_bad;
    logic [TKT_W-1:0]   next_q;
    logic [TKT_W-1:0]   serve_q;
    logic [HINT_W-1:0]  hint_vec;

    assign eligible = acq_req & ~held_vec;

    tlk_arbiter #(.NUM_REQ(NUM_REQ)) u_arb (
        .req (eligible),
        .gnt (win),
        .any (win_any)
    );

    for (genvar i = 0; i < NUM_REQ; i++) begin : g_rel
        rel_outcome_t oc;
        assign oc          = classify_release(rel_req[i], own_vec[i]);
        assign rel_good[i] = oc.good;
        assign rel_bad[i]  = oc.bad;
    end

    tlk_counters #(.TKT_W(TKT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .bump_next  (win_any),
        .bump_serve (|rel_good),
        .next_q     (next_q),
        .serve_q    (serve_q)
    );

    for (genvar i = 0; i < NUM_REQ; i++) begin : g_slot
        tlk_slot #(.TKT_W(TKT_W)) u_slot (
            .clk      (clk),
            .rst      (rst),
            .load     (win[i]),
            .load_tkt (next_q),
            .clear    (rel_good[i]),
            .serve    (serve_q),
            .held     (held_vec[i]),
            .own      (own_vec[i]),
            .hint     (hint_vec[i*TKT_W +: TKT_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acq_ack    <= '0;
            acq_ticket <= '0;
            rel_ack    <= '0;
            rel_err    <= 1'b0;
        end else begin
            acq_ack    <= win;
            acq_ticket <= win_any ? next_q : '0;
            rel_ack    <= rel_good;
            rel_err    <= |rel_bad;
        end
    end

    assign granted      = own_vec;
    assign queue_depth  = next_q - serve_q;
    assign backoff_hint = hint_vec;
endmodule

// File: rtl/tlk_checker.sv
module tlk_checker #(
    parameter int NUM_REQ = 4,
    parameter int TKT_W   = 3
) (
    input logic                     clk,
    input logic                     rst,
    input logic [NUM_REQ-1:0]       acq_req,
    input logic [NUM_REQ-1:0]       acq_ack,
    input logic [TKT_W-1:0]         acq_ticket,
    input logic [NUM_REQ-1:0]       rel_req,
    input logic [NUM_REQ-1:0]       rel_ack,
    input logic                     rel_err,
    input logic [NUM_REQ-1:0]       granted,
    input logic [TKT_W-1:0]         queue_depth,
    input logic [NUM_REQ*TKT_W-1:0] backoff_hint
);
    typedef logic [TKT_W-1:0] tkt_t;

    logic run_q;
    always_ff @(posedge clk) begin
        if (rst) run_q <= 1'b0;
        else     run_q <= 1'b1;
    end

    // R5: a single owner at most
    assert_single_owner_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(granted));

    // R2 / R3: one acquire served per cycle
    assert_one_ack_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(acq_ack));

    // R7: an error needs a release attempt in the previous cycle
    assert_err_cause_R7: assert property (@(posedge clk) disable iff (rst)
        run_q && rel_err |-> $past(|rel_req));

    // R10: the depth moves only by issued tickets and accepted releases
    assert_depth_step_R10: assert property (@(posedge clk) disable iff (rst)
        run_q |-> queue_depth ==
            tkt_t'($past(queue_depth) + tkt_t'(|acq_ack) - tkt_t'(|rel_ack)));

    for (genvar i = 0; i < NUM_REQ; i++) begin : g_req
        // R2: an acknowledge follows a request
        assert_ack_cause_R2: assert property (@(posedge clk) disable iff (rst)
            run_q && acq_ack[i] |-> $past(acq_req[i]));

        // R8: ownership ends only through an accepted release
        assert_grant_drop_R8: assert property (@(posedge clk) disable iff (rst)
            run_q && $past(granted[i]) && !granted[i] |-> rel_ack[i]);

        // R11: the owner sees a zero hint
        assert_owner_hint_R11: assert property (@(posedge clk) disable iff (rst)
            granted[i] |-> backoff_hint[i*TKT_W +: TKT_W] == '0);
    end

    // Immediate check on the outputs that are unused above
    always_comb begin
        assert_ticket_idle_R2: assert (rst || run_q !== 1'b1 || |acq_ack || acq_ticket == '0);
    end
endmodule

bind ticket_lock_unit tlk_checker #(.NUM_REQ(NUM_REQ), .TKT_W(TKT_W)) u_chk (.*);

// File: tb/ticket_lock_unit_bench.sv
module ticket_lock_unit_bench;
    localparam int NR = 4;
    localparam int TW = 3;
    localparam int MOD = 1 << TW;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NR-1:0]  acq_req = '0;
    logic [NR-1:0]  acq_ack;
    logic [TW-1:0]  acq_ticket;
    logic [NR-1:0]  rel_req = '0;
    logic [NR-1:0]  rel_ack;
    logic           rel_err;
    logic [NR-1:0]  granted;
    logic [TW-1:0]  queue_depth;
    logic [NR*TW-1:0] backoff_hint;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // model state
    bit m_has [NR];
    int m_tkt [NR];
    int m_next = 0;
    int m_serv = 0;

    always #4 clk = ~clk;

    ticket_lock_unit #(.NUM_REQ(NR), .TKT_W(TW)) u_ticket_lock_unit (
        .clk(clk), .rst(rst), .acq_req(acq_req), .acq_ack(acq_ack),
        .acq_ticket(acq_ticket), .rel_req(rel_req), .rel_ack(rel_ack),
        .rel_err(rel_err), .granted(granted), .queue_depth(queue_depth),
        .backoff_hint(backoff_hint)
    );

    task automatic chk(input string ctx, input string rq, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, ctx, act, exp);
        end
    endtask

    function automatic bit m_owns(input int i);
        return m_has[i] && (m_tkt[i] == m_serv);
    endfunction

    function automatic int m_granted();
        int g = 0;
        for (int i = 0; i < NR; i++) if (m_owns(i)) g |= (1 << i);
        return g;
    endfunction

    function automatic int m_hint(input int i);
        return m_has[i] ? ((m_tkt[i] - m_serv) % MOD + MOD) % MOD : 0;
    endfunction

    // Called at a falling edge: drive, predict, wait one cycle, compare.
    task automatic step(input logic [NR-1:0] a, input logic [NR-1:0] r, input string ctx);
        int win = -1;
        int e_ack = 0, e_tkt = 0, e_rack = 0, e_err = 0;
        acq_req = a;
        rel_req = r;
        for (int i = NR - 1; i >= 0; i--) if (a[i] && !m_has[i]) win = i;
        for (int i = 0; i < NR; i++) begin
            if (r[i] && m_owns(i)) e_rack |= (1 << i);
            else if (r[i])         e_err = 1;
        end
        if (win >= 0) begin
            e_ack = 1 << win;
            e_tkt = m_next;
        end
        for (int i = 0; i < NR; i++) if (e_rack[i]) begin
            m_has[i] = 1'b0;
            m_serv = (m_serv + 1) % MOD;
        end
        if (win >= 0) begin
            m_has[win] = 1'b1;
            m_tkt[win] = m_next;
            m_next = (m_next + 1) % MOD;
        end
        @(negedge clk);
        chk(ctx, "R2 ack",    int'(acq_ack), e_ack);
        chk(ctx, "R2 ticket", int'(acq_ticket), e_tkt);
        chk(ctx, "R6 rel_ack", int'(rel_ack), e_rack);
        chk(ctx, "R7 rel_err", int'(rel_err), e_err);
        chk(ctx, "R5 granted", int'(granted), m_granted());
        chk(ctx, "R10 depth", int'(queue_depth), ((m_next - m_serv) % MOD + MOD) % MOD);
        for (int i = 0; i < NR; i++)
            chk(ctx, "R11 hint", int'(backoff_hint[i*TW +: TW]), m_hint(i));
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1CE7));
        for (int i = 0; i < NR; i++) begin m_has[i] = 1'b0; m_tkt[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("reset", "R1 granted", int'(granted), 0);
        chk("reset", "R1 depth", int'(queue_depth), 0);
        chk("reset", "R1 acks", int'(acq_ack) | int'(rel_ack) | int'(rel_err), 0);
        chk("reset", "R1 hint", int'(backoff_hint), 0);

        // R3: all requesters at once, held, served lowest index first
        for (int k = 0; k < NR; k++) step(4'hF, 4'h0, "R3 simultaneous");
        chk("R3 order", "R3 owner", int'(granted), 1);
        // R4: re-acquire while holding a ticket
        step(4'h1, 4'h0, "R4 reacquire");
        step(4'hF, 4'h0, "R4 all holding");
        // R7: release from a waiter is ignored
        step(4'h0, 4'h4, "R7 bad release");
        step(4'h0, 4'h0, "R7 idle");
        // R6/R8: owner hands over in ticket order
        step(4'h0, 4'h1, "R6 release owner");
        chk("R8 handover", "R8 owner", int'(granted), 2);
        step(4'h0, 4'h2, "R8 second release");
        step(4'h1, 4'h4, "R8 rejoin and release");
        chk("R8 order", "R8 owner", int'(granted), 8);

        // R9: random mix, counters wrap many times
        for (int n = 0; n < 3000; n++) begin
            logic [NR-1:0] a, r;
            int sel;
            a = NR'($urandom);
            r = '0;
            sel = $urandom % 8;
            if (sel < 4) begin
                for (int i = 0; i < NR; i++) if (m_owns(i)) r[i] = 1'b1;
            end else if (sel == 4) begin
                r[$urandom % NR] = 1'b1;
            end
            step(a, r, "R9 random");
        end

        acq_req = '0;
        rel_req = '0;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule